// File: doc/BRIEF.md
# Successive-Approximation Converter Control

This block is the digital half of a 10-bit successive-approximation analog-to-digital converter that sits on a byte-wide processor bus. Three byte registers are exposed. The control/status register holds a 4-bit input selector and a "finished" flag. The result-high and result-low registers hold the last completed result, aligned to the left.

Software picks an input and launches a conversion with one write to the control register that leaves the flag bit at 0. The block first spends one cycle sampling. It then walks the 10 result bits from the most significant down to the least significant. For each bit it drives a trial code to an external reference-ladder generator and reads a single comparator bit back. When the walk ends, it stores the result, raises the flag and emits a one-cycle interrupt request.

The ladder, comparator and analog multiplexer are outside the block. The block only drives a one-hot input select. It also drives a separate line that tells the shared external-interrupt logic to disregard its pin while that pin is being used as an analog input.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, the control register reads 0x10 (flag set, selector 0000), both result registers read 0x00, input 0 is selected, the trial code is 0 and the interrupt request is low.
- R2: A write to address 0x32 with bit 4 = 0 starts a conversion. From the cycle after that write until completion, control bit 4 reads 0.
- R3: A conversion takes one sample cycle plus 10 trial cycles. Control bit 4 reads 1 starting 11 clock edges after the starting write edge. The result equals the successive-approximation value: bits are decided MSB first, and each bit is kept only when the comparator input reports input ≥ trial code.
- R4: The address 0x34 returns result bits 9:2. Address 0x33 returns result bits 1:0 in bits 7:6, and 0 in bits 5:0. In the control register, bits 7:5 read 0, bit 4 is the flag and bits 3:0 are the selector.
- R5: The result registers change only at completion. A read during a conversion returns the previous result.
- R6: The interrupt request is high for exactly one cycle, in the same cycle in which the flag first reads 1.
- R7: Selector codes 0..11 drive only bit n of the 12-bit input-select output. Codes 12..15 drive it all zero, and a conversion with such a code gives 0 regardless of the comparator.
- R8: The external-interrupt block output is high exactly while the selector holds 1010.
- R9: Writing bit 4 = 0 while a conversion is running aborts it and restarts from the sample cycle. Completion then comes 11 edges after the restarting write, and not at the original time.
- R10: A control write with bit 4 = 1 updates only the selector. It neither starts nor ends a conversion, and the flag keeps its value.
- R11: The trial code is 0 outside the trial cycles. The first trial presents 0x200, and the second presents 0x100 or 0x300 depending on whether the first bit was kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| dac_code | output | 10 | Trial code sent to the reference-ladder generator |
| cmp_ge | input | 1 | Comparator: 1 when input ≥ trial level |
| chan_sel | output | 12 | One-hot analog input select |
| ext_irq_block | output | 1 | Tells the shared external interrupt to disregard its pin |
| adc_irq | output | 1 | One-cycle conversion-complete interrupt request |

## Verification
The bench targets the edges of the conversion window. If the completion edge is off by one, the flag would be found still low, or already high, on the exact cycle where it should first read 1, and the interrupt would be missing or last two cycles.

An abort-and-restart is issued mid-walk. A design that ignored it would complete at the original time with a result built from a stale sample state. A flag-set write is issued mid-walk. A design that treated it as a start or a stop would shift or cut short the completion.

Reads during a conversion catch result registers that update bit by bit. The unused selector codes, paired with a comparator that always answers "greater", catch a design that builds a full-scale result from no input. Extreme inputs (0, full scale, alternating patterns) catch a wrong keep rule or wrong bit ordering, and the left-justified low register catches a swapped split.

// File: rtl/sar_adc_pkg.sv
`timescale 1ns/1ps
package sar_adc_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SAMPLE = 2'd1,
    SEQ_TRIAL  = 2'd2
  } seq_state_t;

  localparam logic [7:0] ADDR_CTRL_DEF = 8'h32;
  localparam logic [7:0] ADDR_RESL_DEF = 8'h33;
  localparam logic [7:0] ADDR_RESH_DEF = 8'h34;
endpackage

// File: rtl/sar_chan_dec.sv
`timescale 1ns/1ps
module sar_chan_dec #(
  parameter int CH_W     = 4,
  parameter int N_CH     = 12,
  parameter int BLOCK_CH = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH_W-1:0] chan_code,
  output logic [N_CH-1:0] chan_sel,
  output logic            chan_valid,
  output logic            ext_block
);
  for (genvar i = 0; i < N_CH; i++) begin : g_sel
    assign chan_sel[i] = (chan_code == CH_W'(i));
  end

  assign chan_valid = |chan_sel;
  assign ext_block  = (chan_code == CH_W'(BLOCK_CH));

  AST_ONE_INPUT_AT_MOST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_sel)) else $error("more than one input selected"); // R7
endmodule

// File: rtl/sar_regs.sv
`timescale 1ns/1ps
module sar_regs #(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 8,
  parameter int              CH_W      = 4,
  parameter int              RES_W     = 10,
  parameter int              FLAG_BIT  = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h32,
  parameter logic [ADDR_W-1:0] RESL_ADDR = 8'h33,
  parameter logic [ADDR_W-1:0] RESH_ADDR = 8'h34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              done_flag,
  input  logic [RES_W-1:0]  result,
  output logic [CH_W-1:0]   chan_code,
  output logic              start_evt
);
  localparam int LO_W = RES_W - DATA_W;

  logic ctrl_hit;
  logic unused_wdata;

  assign ctrl_hit     = bus_wr && (bus_addr == CTRL_ADDR);
  assign start_evt    = ctrl_hit && !bus_wdata[FLAG_BIT];
  assign unused_wdata = ^bus_wdata[DATA_W-1:FLAG_BIT+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chan_code <= '0;
    else if (ctrl_hit) chan_code <= bus_wdata[CH_W-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_ADDR) begin
      bus_rdata[CH_W-1:0] = chan_code;
      bus_rdata[FLAG_BIT] = done_flag;
    end else if (bus_addr == RESL_ADDR) begin
      bus_rdata[DATA_W-1 -: LO_W] = result[LO_W-1:0];
    end else if (bus_addr == RESH_ADDR) begin
      bus_rdata = result[RES_W-1 -: DATA_W];
    end
  end
endmodule

// File: rtl/sar_seq.sv
`timescale 1ns/1ps
module sar_seq
  import sar_adc_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic             cmp_ge,
  input  logic             chan_valid,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result,
  output logic             done_flag,
  output logic             irq
);
  localparam int IDX_W = $clog2(RES_W);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);

  seq_state_t       st;
  logic [IDX_W-1:0] idx;
  logic [RES_W-1:0] acc;
  logic [RES_W-1:0] next_acc;
  logic             busy;
  logic             last_trial;
  logic             trial_hit;

  function automatic logic [RES_W-1:0] trial_code(input logic [RES_W-1:0] kept,
                                                  input logic [IDX_W-1:0] pos);
    return kept | (RES_W'(1) << pos);
  endfunction

  assign busy       = (st != SEQ_IDLE);
  assign last_trial = (st == SEQ_TRIAL) && (idx == '0);
  assign trial_hit  = cmp_ge && chan_valid;
  assign next_acc   = trial_hit ? trial_code(acc, idx) : acc;
  assign dac_code   = (st == SEQ_TRIAL) ? trial_code(acc, idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SEQ_IDLE;
      idx       <= '0;
      acc       <= '0;
      result    <= '0;
      done_flag <= 1'b1;
      irq       <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (start_evt) begin
        st        <= SEQ_SAMPLE;
        done_flag <= 1'b0;
        acc       <= '0;
      end else begin
        case (st)
          SEQ_SAMPLE: begin
            st  <= SEQ_TRIAL;
            idx <= TOP_IDX;
            acc <= '0;
          end
          SEQ_TRIAL: begin
            acc <= next_acc;
            if (idx == '0) begin
              st        <= SEQ_IDLE;
              result    <= next_acc;
              done_flag <= 1'b1;
              irq       <= 1'b1;
            end else begin
              idx <= idx - 1'b1;
            end
          end
          default: st <= SEQ_IDLE;
        endcase
      end
    end
  end

  AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq) else $error("interrupt longer than one cycle"); // R6
  AST_IRQ_ON_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> irq) else $error("flag rose without interrupt"); // R6
  AST_FLAG_LOW_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done_flag) else $error("flag high during conversion"); // R2
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_trial) |=> $stable(result)) else $error("result moved mid-walk"); // R5
  AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SEQ_IDLE) |-> (dac_code == '0)) else $error("trial code while idle"); // R11
endmodule

// File: rtl/sar_adc_ctrl.sv
`timescale 1ns/1ps
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 8,
  parameter int              RES_W     = 10,
  parameter int              CH_W      = 4,
  parameter int              N_CH      = 12,
  parameter int              BLOCK_CH  = 10,
  parameter int              FLAG_BIT  = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_CTRL_DEF,
  parameter logic [ADDR_W-1:0] RESL_ADDR = ADDR_RESL_DEF,
  parameter logic [ADDR_W-1:0] RESH_ADDR = ADDR_RESH_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [RES_W-1:0]  dac_code,
  input  logic              cmp_ge,
  output logic [N_CH-1:0]   chan_sel,
  output logic              ext_irq_block,
  output logic              adc_irq
);
  logic [CH_W-1:0]  chan_code;
  logic             start_evt;
  logic             done_flag;
  logic             chan_valid;
  logic [RES_W-1:0] result;

  sar_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W), .RES_W(RES_W),
    .FLAG_BIT(FLAG_BIT), .CTRL_ADDR(CTRL_ADDR), .RESL_ADDR(RESL_ADDR),
    .RESH_ADDR(RESH_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_flag(done_flag),
    .result(result), .chan_code(chan_code), .start_evt(start_evt)
  );

  sar_chan_dec #(.CH_W(CH_W), .N_CH(N_CH), .BLOCK_CH(BLOCK_CH)) u_dec (
    .clk(clk), .rst_n(rst_n), .chan_code(chan_code), .chan_sel(chan_sel),
    .chan_valid(chan_valid), .ext_block(ext_irq_block)
  );

  sar_seq #(.RES_W(RES_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .cmp_ge(cmp_ge),
    .chan_valid(chan_valid), .dac_code(dac_code), .result(result),
    .done_flag(done_flag), .irq(adc_irq)
  );

  AST_BLOCK_ONLY_ON_SHARED_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq_block |-> chan_sel[BLOCK_CH]) else $error("block without shared input"); // R8
  AST_NO_HIT_WITHOUT_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_irq && !chan_valid) |-> (result == '0)) else $error("result from no input"); // R7
endmodule

// File: tb/test_sar_adc_ctrl.sv
`timescale 1ns/1ps
module test_sar_adc_ctrl;
  localparam logic [7:0] A_CTRL = 8'h32;
  localparam logic [7:0] A_RESL = 8'h33;
  localparam logic [7:0] A_RESH = 8'h34;
  localparam int NV = 9;
  // {selector, input value, expected result}
  localparam logic [23:0] VEC [NV] = '{
    {4'd0,  10'h000, 10'h000},
    {4'd1,  10'h3FF, 10'h3FF},
    {4'd5,  10'h155, 10'h155},
    {4'd7,  10'h2AA, 10'h2AA},
    {4'd8,  10'h200, 10'h200},
    {4'd10, 10'h1FF, 10'h1FF},
    {4'd11, 10'h001, 10'h001},
    {4'd13, 10'h2C3, 10'h000},
    {4'd15, 10'h3FF, 10'h000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [9:0]  dac_code;
  logic        cmp_ge;
  logic [11:0] chan_sel;
  logic        ext_irq_block;
  logic        adc_irq;
  logic [9:0]  vin [12];
  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sar_adc_ctrl i_sar_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dac_code(dac_code),
    .cmp_ge(cmp_ge), .chan_sel(chan_sel), .ext_irq_block(ext_irq_block),
    .adc_irq(adc_irq)
  );

  // Comparator model; with no input selected it always answers "greater".
  always_comb begin
    cmp_ge = 1'b1;
    for (int k = 0; k < 12; k++) if (chan_sel[k]) cmp_ge = (vin[k] >= dac_code);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic skip(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic expect_result(input string req, input logic [9:0] r);
    logic [7:0] d;
    rd(A_RESH, d); check(req, d, r[9:2]);
    rd(A_RESL, d); check(req, d, {r[1:0], 6'b0});
  endtask

  task automatic run_vec(input logic [3:0] ch, input logic [9:0] v, input logic [9:0] exp);
    logic [7:0] d;
    logic [11:0] sel_exp;
    sel_exp = (ch < 12) ? (12'h001 << ch) : 12'h000;
    if (ch < 12) vin[ch] = v;
    wr(A_CTRL, {4'b0000, ch});                       // N1
    rd(A_CTRL, d); check("R2 flag low after start", d, {4'b0000, ch});
    check("R7 one-hot select", chan_sel, sel_exp);
    check("R8 interrupt block", ext_irq_block, (ch == 4'd10));
    skip(10);                                         // N11
    rd(A_CTRL, d); check("R3 not done one edge early", d[4], 1'b0);
    check("R6 no early irq", adc_irq, 1'b0);
    skip(1);                                          // N12
    rd(A_CTRL, d); check("R3 done on edge 11", d, {4'b0001, ch});
    check("R6 irq with flag", adc_irq, 1'b1);
    expect_result("R4 R7 result layout", exp);
    skip(1);
    check("R6 irq single cycle", adc_irq, 1'b0);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    for (int k = 0; k < 12; k++) vin[k] = 10'h000;
    skip(3);
    rst_n = 1'b1;
    skip(1);

    // R1 reset state
    rd(A_CTRL, d); check("R1 ctrl reset", d, 8'h10);
    rd(A_RESH, d); check("R1 high reset", d, 8'h00);
    rd(A_RESL, d); check("R1 low reset", d, 8'h00);
    check("R1 select input 0", chan_sel, 12'h001);
    check("R1 irq low", adc_irq, 1'b0);
    check("R1 trial code 0", dac_code, 10'h000);

    // table of vectors: R3 R4 R6 R7 R8
    for (int i = 0; i < NV; i++) run_vec(VEC[i][23:20], VEC[i][19:10], VEC[i][9:0]);

    // R11 trial code sequence
    vin[3] = 10'h155;
    wr(A_CTRL, 8'h03);                                // N1
    check("R11 zero in sample", dac_code, 10'h000);
    skip(1); check("R11 first trial midscale", dac_code, 10'h200);
    skip(1); check("R11 second trial after reject", dac_code, 10'h100);
    skip(9); expect_result("R3 result after walk", 10'h155);

    // R5 stale result during conversion
    vin[3] = 10'h3C0;
    wr(A_CTRL, 8'h03);
    skip(5); expect_result("R5 previous result held", 10'h155);
    skip(6); expect_result("R5 new result at completion", 10'h3C0);

    // R9 abort and restart
    vin[3] = 10'h0AB;
    wr(A_CTRL, 8'h03);                                // N1
    skip(3);                                          // N4
    wr(A_CTRL, 8'h03);                                // N5
    skip(7);                                          // N12
    rd(A_CTRL, d); check("R9 no completion at original time", d[4], 1'b0);
    check("R9 no irq at original time", adc_irq, 1'b0);
    skip(4);                                          // N16
    rd(A_CTRL, d); check("R9 completion after restart", d[4], 1'b1);
    check("R9 irq after restart", adc_irq, 1'b1);
    expect_result("R9 restarted result", 10'h0AB);

    // R10 flag-set write during conversion
    vin[6] = 10'h2F0;
    wr(A_CTRL, 8'h06);                                // N1
    skip(2);                                          // N3
    wr(A_CTRL, 8'h16);                                // N4
    rd(A_CTRL, d); check("R10 flag stays low", d, 8'h06);
    skip(7);                                          // N11
    rd(A_CTRL, d); check("R10 not ended early", d[4], 1'b0);
    skip(1);                                          // N12
    check("R10 completes on time", adc_irq, 1'b1);
    expect_result("R10 result intact", 10'h2F0);

    // R10 flag-set write while idle, R8 shared input
    wr(A_CTRL, 8'h1A);
    rd(A_CTRL, d); check("R10 selector only", d, 8'h1A);
    check("R8 block on 1010", ext_irq_block, 1'b1);
    skip(12);
    check("R10 no conversion from idle write", adc_irq, 1'b0);
    expect_result("R10 result untouched", 10'h2F0);
    wr(A_CTRL, 8'h1B);
    check("R8 block released", ext_irq_block, 1'b0);

    // R4 unused control bits read zero
    vin[5] = 10'h0F0;
    wr(A_CTRL, 8'hE5);
    rd(A_CTRL, d); check("R4 upper ctrl bits zero", d, 8'h05);
    skip(11);
    expect_result("R4 result after masked write", 10'h0F0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule